// File: doc/BRIEF.md
# Programmable Logic Cell Chain

This block models a single programmable logic cell of a lookup-table fabric and strings a few of them into a short chain. Each cell holds a 16-bit truth table addressed by four data lines. It also has a register whose next-state rule can be set to D, T, JK or SR. Two independently routed outputs can each carry either the combinational result or the register. Dedicated carry and cascade links run directly between neighbouring cells. The configuration of each cell arrives as a static word on an input port, so a test harness or a higher-level fabric model can reprogram any cell between cycles.

In normal mode the table yields one function of all four data inputs. In arithmetic mode it splits into two 3-input tables over data1, data2 and the incoming carry: the low half gives the sum and the high half gives the outgoing carry. The cascade stage merges the table result with the previous cell's cascade value by AND or OR. The merged value is the cell's combinational result and is also passed on as its cascade-out. The register can take its data from data4 directly instead of from the table. One output can then carry a table function while the other carries an unrelated stored bit.

Top module: `lcell_chain`

## Requirements
- R1: In normal mode (config bit 18 = 0) with cascade unused, a cell's combinational result is bit {data4,data3,data2,data1} of its 16-bit table (config bits 15:0). Data1 is bit 0 of the cell's 4-bit data slice.
- R2: In arithmetic mode (config bit 18 = 1), the result is table bit {cin,data2,data1} and the carry-out is table bit 8+{cin,data2,data1}. In normal mode the carry-out equals the carry-in.
- R3: The result is the table value combined with the cascade input. Config bit 19 picks AND (0) or OR (1). When config bit 20 is 0 the cascade input is replaced by the identity value (1 for AND, 0 for OR). A cell's cascade-out equals its result.
- R4: The local output (select bit 22) and the routing output (select bit 23) each show the register when their bit is 1 and the combinational result when it is 0, independently of each other.
- R5: Register mode is set by config bits 17:16: 0 = D, 1 = T, 2 = JK, 3 = SR. In D mode the register loads its data source. In T mode it inverts when the source is 1.
- R6: In JK mode J = data1 and K = data2. 00 holds, 10 sets, 01 clears and 11 inverts the register.
- R7: In SR mode S = data1 and R = data2. 10 sets, 01 clears, and both 00 and 11 hold the register.
- R8: With config bit 21 = 1, the D/T data source is data4 instead of the combinational result, so the register can store data unrelated to the table.
- R9: While a cell's clock enable is low, its register holds on the clock edge.
- R10: Chip reset (low) clears every register asynchronously and overrides everything. A cell's clear (low) forces 0 and wins over its preset (low), which forces 1.
- R11: Cell k takes its carry-in and cascade-in from cell k-1. Cell 0 takes them from the chain inputs, and the last cell drives the chain outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell registers |
| rst_chip_n | input | 1 | Chip-wide asynchronous reset, active low |
| cfg_i | input | N_CELLS*24 | Configuration word per cell, cell k in bits [24k+23:24k] |
| data_i | input | N_CELLS*4 | Four data lines per cell, data1 at bit 4k |
| ena_i | input | N_CELLS | Clock enable per cell |
| clr_n_i | input | N_CELLS | Asynchronous clear per cell, active low |
| pre_n_i | input | N_CELLS | Asynchronous preset per cell, active low |
| carry_i | input | 1 | Carry into cell 0 |
| cascade_i | input | 1 | Cascade value into cell 0 |
| local_o | output | N_CELLS | Local output of each cell |
| route_o | output | N_CELLS | Routing output of each cell |
| carry_o | output | 1 | Carry out of the last cell |
| cascade_o | output | 1 | Cascade out of the last cell |

## Verification
The bench targets the SR case with both inputs high. A design that treats it as set or as toggle would change the stored bit instead of holding it. Clear and preset are driven low together, and a wrong priority would leave a 1 where 0 is expected. Cascade-in is toggled while the cascade-use bit is off: an AND chain that lacks the identity substitution would force results to 0, and an OR chain that lacks it would force them to 1. Arithmetic chains run the carry through every cell, which exposes a swapped sum/carry half of the table or a carry that skips a cell.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    localparam int LUT_IN    = 4;
    localparam int LUT_BITS  = 1 << LUT_IN;
    localparam int ARITH_IN  = 3;
    localparam int HALF_BITS = LUT_BITS / 2;
    localparam int CFG_W     = LUT_BITS + 8;

    typedef enum logic [1:0] {
        RM_D  = 2'd0,
        RM_T  = 2'd1,
        RM_JK = 2'd2,
        RM_SR = 2'd3
    } reg_mode_e;

    // MSB first: mask lands in bits 15:0, route select in bit 23
    typedef struct packed {
        logic                route_reg;
        logic                local_reg;
        logic                reg_from_d4;
        logic                casc_use;
        logic                casc_or;
        logic                arith;
        reg_mode_e           mode;
        logic [LUT_BITS-1:0] mask;
    } cell_cfg_t;

    typedef struct packed {
        logic q;
    } ff_state_t;
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut
    import lcell_pkg::*;
(
    input  cell_cfg_t         cfg_i,
    input  logic [LUT_IN-1:0] data_i,
    input  logic              carry_i,
    input  logic              casc_i,
    output logic              result_o,
    output logic              carry_o
);
    logic [HALF_BITS-1:0] sum_tab;
    logic [HALF_BITS-1:0] cry_tab;
    logic [ARITH_IN-1:0]  a_idx;
    logic                 tab_bit;
    logic                 casc_eff;

    always_comb begin
        sum_tab = cfg_i.mask[HALF_BITS-1:0];
        cry_tab = cfg_i.mask[LUT_BITS-1:HALF_BITS];
        a_idx   = {carry_i, data_i[1], data_i[0]};
        if (cfg_i.arith) begin
            tab_bit = sum_tab[a_idx];
            carry_o = cry_tab[a_idx];
        end else begin
            tab_bit = cfg_i.mask[data_i];
            carry_o = carry_i;
        end
        // an unused cascade input behaves as the identity of the chosen operator
        casc_eff = cfg_i.casc_use ? casc_i : ~cfg_i.casc_or;
        result_o = cfg_i.casc_or ? (tab_bit | casc_eff) : (tab_bit & casc_eff);
    end
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff
    import lcell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_chip_n,
    input  logic      clr_n,
    input  logic      pre_n,
    input  logic      ena,
    input  reg_mode_e mode,
    input  logic      src,
    input  logic      in_a,
    input  logic      in_b,
    output logic      q_o
);
    ff_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ena) begin
            unique case (mode)
                RM_D:  st_d.q = src;
                RM_T:  st_d.q = st_q.q ^ src;
                RM_JK: begin
                    unique case ({in_a, in_b})
                        2'b10:   st_d.q = 1'b1;
                        2'b01:   st_d.q = 1'b0;
                        2'b11:   st_d.q = ~st_q.q;
                        default: st_d.q = st_q.q;
                    endcase
                end
                RM_SR: begin
                    unique case ({in_a, in_b})
                        2'b10:   st_d.q = 1'b1;
                        2'b01:   st_d.q = 1'b0;
                        default: st_d.q = st_q.q;
                    endcase
                end
                default: st_d.q = st_q.q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_chip_n or negedge clr_n or negedge pre_n) begin
        if (!rst_chip_n) begin
            st_q <= '0;
        end else if (!clr_n) begin
            st_q <= '0;
        end else if (!pre_n) begin
            st_q.q <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.q;
endmodule

// File: rtl/lcell_cell.sv
module lcell_cell
    import lcell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_chip_n,
    input  cell_cfg_t         cfg_i,
    input  logic [LUT_IN-1:0] data_i,
    input  logic              ena_i,
    input  logic              clr_n_i,
    input  logic              pre_n_i,
    input  logic              carry_i,
    input  logic              casc_i,
    output logic              local_o,
    output logic              route_o,
    output logic              carry_o,
    output logic              casc_o,
    output logic              q_o
);
    logic comb_res;
    logic reg_src;
    logic reg_q;

    lcell_lut u_lut (
        .cfg_i    (cfg_i),
        .data_i   (data_i),
        .carry_i  (carry_i),
        .casc_i   (casc_i),
        .result_o (comb_res),
        .carry_o  (carry_o)
    );

    assign reg_src = cfg_i.reg_from_d4 ? data_i[LUT_IN-1] : comb_res;

    lcell_ff u_ff (
        .clk        (clk),
        .rst_chip_n (rst_chip_n),
        .clr_n      (clr_n_i),
        .pre_n      (pre_n_i),
        .ena        (ena_i),
        .mode       (cfg_i.mode),
        .src        (reg_src),
        .in_a       (data_i[0]),
        .in_b       (data_i[1]),
        .q_o        (reg_q)
    );

    assign local_o = cfg_i.local_reg ? reg_q : comb_res;
    assign route_o = cfg_i.route_reg ? reg_q : comb_res;
    assign casc_o  = comb_res;
    assign q_o     = reg_q;
endmodule

// File: rtl/lcell_chain.sv
module lcell_chain
    import lcell_pkg::*;
#(
    parameter int N_CELLS = 4,
    localparam int CW = N_CELLS * CFG_W,
    localparam int DW = N_CELLS * LUT_IN
) (
    input  logic               clk,
    input  logic               rst_chip_n,
    input  logic [CW-1:0]      cfg_i,
    input  logic [DW-1:0]      data_i,
    input  logic [N_CELLS-1:0] ena_i,
    input  logic [N_CELLS-1:0] clr_n_i,
    input  logic [N_CELLS-1:0] pre_n_i,
    input  logic               carry_i,
    input  logic               cascade_i,
    output logic [N_CELLS-1:0] local_o,
    output logic [N_CELLS-1:0] route_o,
    output logic               carry_o,
    output logic               cascade_o
);
    logic [N_CELLS:0]   carry_link;
    logic [N_CELLS:0]   casc_link;
    logic [N_CELLS-1:0] reg_q;

    assign carry_link[0] = carry_i;
    assign casc_link[0]  = cascade_i;

    for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
        cell_cfg_t cfg_k;
        assign cfg_k = cfg_i[k*CFG_W +: CFG_W];

        lcell_cell u_cell (
            .clk        (clk),
            .rst_chip_n (rst_chip_n),
            .cfg_i      (cfg_k),
            .data_i     (data_i[k*LUT_IN +: LUT_IN]),
            .ena_i      (ena_i[k]),
            .clr_n_i    (clr_n_i[k]),
            .pre_n_i    (pre_n_i[k]),
            .carry_i    (carry_link[k]),
            .casc_i     (casc_link[k]),
            .local_o    (local_o[k]),
            .route_o    (route_o[k]),
            .carry_o    (carry_link[k+1]),
            .casc_o     (casc_link[k+1]),
            .q_o        (reg_q[k])
        );
    end

    assign carry_o   = carry_link[N_CELLS];
    assign cascade_o = casc_link[N_CELLS];
endmodule

// File: rtl/lcell_chain_chk.sv
module lcell_chain_chk
    import lcell_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input logic                        clk,
    input logic                        rst_chip_n,
    input logic [N_CELLS*CFG_W-1:0]    cfg_i,
    input logic [N_CELLS*LUT_IN-1:0]   data_i,
    input logic [N_CELLS-1:0]          ena_i,
    input logic [N_CELLS-1:0]          clr_n_i,
    input logic [N_CELLS-1:0]          pre_n_i,
    input logic [N_CELLS-1:0]          reg_q
);
    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        cell_cfg_t         c;
        logic [LUT_IN-1:0] d;
        logic              quiet;
        assign c     = cfg_i[i*CFG_W +: CFG_W];
        assign d     = data_i[i*LUT_IN +: LUT_IN];
        assign quiet = clr_n_i[i] && pre_n_i[i];

        always @(posedge clk) begin
            if (!rst_chip_n) begin
                AST_CHIP_RESET_CLEARS: assert (reg_q[i] == 1'b0); // R10
            end
        end

        AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_chip_n)
            !clr_n_i[i] |-> !reg_q[i]); // R10

        AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_chip_n)
            (clr_n_i[i] && !pre_n_i[i]) |=> (!clr_n_i[i] || reg_q[i])); // R10

        AST_ENA_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_chip_n)
            (quiet && !ena_i[i]) |=> (!quiet || $stable(reg_q[i]))); // R9

        AST_SR_BOTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_chip_n)
            (quiet && ena_i[i] && c.mode == RM_SR && d[0] && d[1])
            |=> (!quiet || $stable(reg_q[i]))); // R7

        AST_JK_BOTH_TOGGLES: assert property (@(posedge clk) disable iff (!rst_chip_n)
            (quiet && ena_i[i] && c.mode == RM_JK && d[0] && d[1])
            |=> (!quiet || reg_q[i] != $past(reg_q[i]))); // R6
    end
endmodule

bind lcell_chain lcell_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk        (clk),
    .rst_chip_n (rst_chip_n),
    .cfg_i      (cfg_i),
    .data_i     (data_i),
    .ena_i      (ena_i),
    .clr_n_i    (clr_n_i),
    .pre_n_i    (pre_n_i),
    .reg_q      (reg_q)
);

// File: tb/sim_lcell_chain.sv
module sim_lcell_chain;
    localparam int N = 4;
    localparam int W = 24;

    logic           clk = 1'b0;
    logic           rst_n = 1'b1;
    logic [N*W-1:0] cfg = '0;
    logic [N*4-1:0] data = '0;
    logic [N-1:0]   ena = '1;
    logic [N-1:0]   clr_n = '1;
    logic [N-1:0]   pre_n = '1;
    logic           cin = 1'b0;
    logic           sin = 1'b0;
    logic [N-1:0]   loc, rte;
    logic           cout, sout;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done = 0;
    bit  mq [N];
    bit  m_res [N];
    bit  m_cout, m_sout;

    always #10 clk = ~clk;

    lcell_chain #(.N_CELLS(N)) u0 (
        .clk(clk), .rst_chip_n(rst_n), .cfg_i(cfg), .data_i(data),
        .ena_i(ena), .clr_n_i(clr_n), .pre_n_i(pre_n),
        .carry_i(cin), .cascade_i(sin),
        .local_o(loc), .route_o(rte), .carry_o(cout), .cascade_o(sout)
    );

    // behavioural reference: combinational chain from current inputs
    task automatic evaluate();
        bit c, s;
        c = cin;
        s = sin;
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] cf;
            logic [3:0]   d;
            int           idx;
            bit           f, cn, ce, r;
            cf = cfg[k*W +: W];
            d  = data[k*4 +: 4];
            if (cf[18]) begin
                idx = (c ? 4 : 0) + (d[1] ? 2 : 0) + (d[0] ? 1 : 0);
                f   = cf[idx];
                cn  = cf[8 + idx];
            end else begin
                idx = int'(d);
                f   = cf[idx];
                cn  = c;
            end
            ce = cf[20] ? s : !cf[19];
            r  = cf[19] ? (f | ce) : (f & ce);
            m_res[k] = r;
            c = cn;
            s = r;
        end
        m_cout = c;
        m_sout = s;
    endtask

    function automatic bit next_q(int k, bit q);
        logic [W-1:0] cf;
        logic [3:0]   d;
        bit           src;
        cf  = cfg[k*W +: W];
        d   = data[k*4 +: 4];
        src = cf[21] ? d[3] : m_res[k];
        case (cf[17:16])
            2'd0: return src;
            2'd1: return q ^ src;
            2'd2: return (d[0] && d[1]) ? !q : (d[0] ? 1'b1 : (d[1] ? 1'b0 : q));
            default: return (d[0] && !d[1]) ? 1'b1 : ((!d[0] && d[1]) ? 1'b0 : q);
        endcase
    endfunction

    always @(posedge clk) begin
        evaluate();
        for (int k = 0; k < N; k++) begin
            if (!rst_n || !clr_n[k]) mq[k] = 1'b0;
            else if (!pre_n[k])      mq[k] = 1'b1;
            else if (ena[k])         mq[k] = next_q(k, mq[k]);
        end
    end

    task automatic cmp(string tag, string what, int k, bit act, bit exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s cell %0d: actual %b expected %b", tag, what, k, act, exp);
        end
    endtask

    task automatic check(string tag);
        evaluate();
        for (int k = 0; k < N; k++) begin
            logic [W-1:0] cf;
            cf = cfg[k*W +: W];
            cmp(tag, "local", k, loc[k], cf[22] ? mq[k] : m_res[k]);
            cmp(tag, "route", k, rte[k], cf[23] ? mq[k] : m_res[k]);
        end
        cmp(tag, "carry_o", N, cout, m_cout);
        cmp(tag, "cascade_o", N, sout, m_sout);
    endtask

    // kinds: 0 reset, 1 lut, 2 arith, 3 cascade, 4 select, 5 packing,
    //        6 D/T, 7 JK, 8 SR, 9 enable, 10 async, 11 chain
    function automatic logic [W-1:0] make_cfg(int kind);
        logic [W-1:0] cf;
        cf = W'($urandom);
        cf[18] = 1'b0;
        cf[20] = 1'b0;
        cf[21] = 1'b0;
        cf[22] = 1'b0;
        cf[23] = 1'b1;
        case (kind)
            1: begin cf[17:16] = 2'd0; cf[23] = 1'b0; end
            2: begin cf[18] = 1'b1; cf[23] = 1'b0; end
            3: begin cf[20] = ($urandom % 4) != 0; end
            4: begin cf[22] = $urandom; cf[23] = $urandom; cf[21] = $urandom; end
            5: begin cf[21] = 1'b1; cf[17] = 1'b0; end
            6: begin cf[17] = 1'b0; cf[22] = 1'b1; end
            7: begin cf[17:16] = 2'd2; cf[22] = 1'b1; end
            8: begin cf[17:16] = 2'd3; cf[22] = 1'b1; end
            11: begin cf[18] = 1'b1; cf[20] = 1'b1; cf[22] = $urandom; end
            default: ;
        endcase
        return cf;
    endfunction

    task automatic run_phase(string tag, int kind, int cycles);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            check(tag);
            if (n % 8 == 0)
                for (int k = 0; k < N; k++) cfg[k*W +: W] = make_cfg(kind);
            data = (N*4)'($urandom);
            if (kind == 7 || kind == 8)
                for (int k = 0; k < N; k++)
                    if ($urandom % 2 == 0) data[k*4 +: 2] = 2'b11;
            cin = $urandom;
            sin = $urandom;
            rst_n = (kind == 0) ? 1'b0 : ((kind == 10 && n % 23 == 5) ? 1'b0 : 1'b1);
            ena = (kind == 9) ? N'($urandom) : '1;
            for (int k = 0; k < N; k++) begin
                clr_n[k] = (kind == 10) ? (($urandom % 4) != 0) : 1'b1;
                pre_n[k] = (kind == 10) ? (($urandom % 3) != 0) : 1'b1;
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        for (int k = 0; k < N; k++) mq[k] = 1'b0;
        // R10: reset state with register outputs selected
        run_phase("R10", 0, 6);
        run_phase("R1", 1, 60);
        run_phase("R2", 2, 60);
        run_phase("R3", 3, 60);
        run_phase("R4", 4, 60);
        run_phase("R8", 5, 60);
        run_phase("R5", 6, 60);
        run_phase("R6", 7, 60);
        run_phase("R7", 8, 60);
        run_phase("R9", 9, 60);
        run_phase("R10", 10, 120);
        run_phase("R11", 11, 80);
        @(negedge clk);
        check("R11");
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R11 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule